// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit byte logical address into a physical address by fetching two page table entries from memory, one after the other. A requester presents the logical address together with the base address of the root table. The walker reads the root-level entry, checks whether the second-level table exists, reads the second-level entry if it does, and returns either a translated address with its rights field or a fault.

The logical address splits into three fields. The top 10 bits select one of 1024 root entries. The next 10 bits select one of 1024 second-level entries. The low 12 bits are the byte offset inside a 4096-byte page. Table entries are 32-bit words, so an index is scaled by 4 to form a byte address. The memory port issues a one-cycle read request and accepts the read data whenever it comes back, after any number of cycles. Only one translation is in progress at a time.

Top module: `page_walk2`

## Requirements
- R1: In the first cycle after reset is released, and in the cycle after any synchronous reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0, even if a walk was in progress.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` stays 0 until the response handshake, and `req_laddr`, `root_base` and `req_valid` are ignored, so later changes to them do not alter the result.
- R3: In the cycle after acceptance `mem_req` is 1 and `mem_addr` equals `root_base + 4 * req_laddr[31:22]`.
- R4: A root entry has its present flag in bit 0 and the second-level table page in bits [31:12]. If the flag is 1, in the cycle after the root entry arrives `mem_req` is 1 and `mem_addr` equals `{entry[31:12], 12'h000} + 4 * req_laddr[21:12]`. Bits [11:1] of a root entry have no effect.
- R5: If the present flag of the root entry is 0, no second read is issued; in the cycle after the root entry arrives `rsp_valid` is 1, `rsp_fault` is 1, and `rsp_paddr` and `rsp_rights` are 0.
- R6: A second-level entry holds the physical page in bits [31:12] and the rights in bits [11:0]. In the cycle after it arrives `rsp_valid` is 1, `rsp_fault` is 0, `rsp_paddr` is `{entry[31:12], req_laddr[11:0]}` and `rsp_rights` is `entry[11:0]`.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, all response outputs hold their values. In the cycle after a handshake, `rsp_valid` is 0 and `req_ready` is 1.
- R8: `mem_rvalid` has no effect while the walker is idle or is holding a response.
- R9: The walker waits any number of cycles, including zero, for `mem_rvalid`. `mem_req` is high for one cycle per read and is not raised again while a read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_laddr | input | 32 | Logical byte address to translate |
| root_base | input | 32 | Byte address of the root table |
| mem_req | output | 1 | One-cycle read request pulse |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 32 | Entry word returned by memory |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Translated physical byte address |
| rsp_rights | output | 12 | Rights field of the second-level entry |
| rsp_fault | output | 1 | Root entry marked the second-level table absent |

## Verification
Each result has a fixed place in time. The root read request is due one cycle after acceptance. The second read, or the fault response, is due one cycle after the root entry is returned. The translated response is due one cycle after the second-level entry is returned. `req_ready` comes back one cycle after the response handshake. The bench plays the memory itself, so it knows the edge at which each entry is consumed. It checks each output at the falling edge that follows that edge. While a read is outstanding, it checks on every falling edge that `mem_req` stays low. While a response is being held, it checks on every falling edge that the response is unchanged.

// File: rtl/pw_pkg.sv
// Package: shared sizes and the control state type of the page walker.
// Assumes: byte addresses, word-sized table entries, power-of-two word size.
package pw_pkg;
    parameter int PW_ADDR_W     = 32;
    parameter int PW_OFF_W      = 12;
    parameter int PW_IDX_W      = 10;
    parameter int PW_WORD_BYTES = 4;

    typedef enum logic [2:0] {
        PW_IDLE    = 3'd0,
        PW_READ_L1 = 3'd1,
        PW_READ_L2 = 3'd2,
        PW_RESP    = 3'd3,
        PW_FAULT   = 3'd4
    } pw_state_e;
endpackage

// File: rtl/pw_addr_calc.sv
// Module: pw_addr_calc
// Combinational address arithmetic of the walker. It forms the root entry
// address from the live request, the second-level entry address from the
// returned root entry, and the physical address and rights from a returned
// second-level entry.
// Assumes: entries are ADDR_W bits wide, present flag in bit 0 of a root entry.
module pw_addr_calc #(
    parameter int ADDR_W     = pw_pkg::PW_ADDR_W,
    parameter int OFF_W      = pw_pkg::PW_OFF_W,
    parameter int IDX_W      = pw_pkg::PW_IDX_W,
    parameter int WORD_BYTES = pw_pkg::PW_WORD_BYTES,
    localparam int LOW_W     = ADDR_W - IDX_W,
    localparam int TBL_W     = LOW_W - OFF_W
) (
    input  logic [IDX_W-1:0]  dir_idx,
    input  logic [ADDR_W-1:0] root,
    input  logic [LOW_W-1:0]  held_low,
    input  logic [ADDR_W-1:0] entry,
    output logic [ADDR_W-1:0] l1_addr,
    output logic [ADDR_W-1:0] l2_addr,
    output logic              present,
    output logic [ADDR_W-1:0] paddr,
    output logic [OFF_W-1:0]  rights
);
    localparam int WORD_SH = $clog2(WORD_BYTES);

    logic [TBL_W-1:0]  tbl_idx;
    logic [ADDR_W-1:0] tbl_base;

    // Purpose: split the held address and scale the indices to byte addresses.
    always_comb begin
        tbl_idx  = held_low[LOW_W-1:OFF_W];
        tbl_base = {entry[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        l1_addr  = root + (ADDR_W'(dir_idx) << WORD_SH);
        l2_addr  = tbl_base + (ADDR_W'(tbl_idx) << WORD_SH);
        present  = entry[0];
        paddr    = {entry[ADDR_W-1:OFF_W], held_low[OFF_W-1:0]};
        rights   = entry[OFF_W-1:0];
    end
endmodule

// File: rtl/pw_req_hold.sv
// Module: pw_req_hold
// Holds the part of the logical address still needed after the root read
// (the second-level index and the page offset), captured at acceptance.
// Assumes: take is asserted only in the cycle a request is accepted.
module pw_req_hold #(
    parameter int LOW_W = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [LOW_W-1:0] low_in,
    output logic [LOW_W-1:0] low_q
);
    // Purpose: capture the untranslated low address bits on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (take) begin
            low_q <= low_in;
        end
    end
endmodule

// File: rtl/pw_walk_ctrl.sv
// Module: pw_walk_ctrl
// Control of the walk: accepts a request, pulses the two memory reads, decides
// on the present flag and signals when the response is captured or released.
// Assumes: one read outstanding at most; mem_rvalid may come in the same cycle
// as mem_req or any number of cycles later.
module pw_walk_ctrl #(
    parameter int ADDR_W = pw_pkg::PW_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] l1_addr,
    input  logic [ADDR_W-1:0] l2_addr,
    input  logic              present,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              accept,
    output logic              cap_ok,
    output logic              cap_fault
);
    import pw_pkg::*;

    pw_state_e         state;
    logic              mem_req_q;
    logic [ADDR_W-1:0] mem_addr_q;

    // Purpose: decode handshake and capture strobes from the current state.
    always_comb begin
        req_ready = (state == PW_IDLE);
        rsp_valid = (state == PW_RESP) || (state == PW_FAULT);
        accept    = req_ready && req_valid;
        cap_ok    = (state == PW_READ_L2) && mem_rvalid;
        cap_fault = (state == PW_READ_L1) && mem_rvalid && !present;
        mem_req   = mem_req_q;
        mem_addr  = mem_addr_q;
    end

    // Purpose: walk state, one-cycle read pulses and the read address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PW_IDLE;
            mem_req_q  <= 1'b0;
            mem_addr_q <= '0;
        end else begin
            mem_req_q <= 1'b0;
            case (state)
                PW_IDLE: begin
                    if (req_valid) begin
                        state      <= PW_READ_L1;
                        mem_req_q  <= 1'b1;
                        mem_addr_q <= l1_addr;
                    end
                end
                PW_READ_L1: begin
                    if (mem_rvalid) begin
                        if (present) begin
                            state      <= PW_READ_L2;
                            mem_req_q  <= 1'b1;
                            mem_addr_q <= l2_addr;
                        end else begin
                            state <= PW_FAULT;
                        end
                    end
                end
                PW_READ_L2: begin
                    if (mem_rvalid) begin
                        state <= PW_RESP;
                    end
                end
                PW_RESP, PW_FAULT: begin
                    if (rsp_ready) begin
                        state <= PW_IDLE;
                    end
                end
                default: state <= PW_IDLE;
            endcase
        end
    end

    AST_ISSUE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (mem_req && mem_addr == $past(l1_addr))); // R3
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> !mem_req); // R9
    AST_NO_READ_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fault |=> (!mem_req && rsp_valid)); // R5
    AST_READY_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid)); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready); // R2
endmodule

// File: rtl/pw_rsp_reg.sv
// Module: pw_rsp_reg
// Response register: loads the translation or a cleared fault result when the
// control strobes it and keeps it until the next walk overwrites it.
// Assumes: cap_ok and cap_fault are never asserted together.
module pw_rsp_reg #(
    parameter int ADDR_W = pw_pkg::PW_ADDR_W,
    parameter int OFF_W  = pw_pkg::PW_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_ok,
    input  logic              cap_fault,
    input  logic [ADDR_W-1:0] paddr_in,
    input  logic [OFF_W-1:0]  rights_in,
    input  logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] paddr_q,
    output logic [OFF_W-1:0]  rights_q,
    output logic              fault_q
);
    // Purpose: load the result of a finished walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            paddr_q  <= '0;
            rights_q <= '0;
            fault_q  <= 1'b0;
        end else if (cap_ok) begin
            paddr_q  <= paddr_in;
            rights_q <= rights_in;
            fault_q  <= 1'b0;
        end else if (cap_fault) begin
            paddr_q  <= '0;
            rights_q <= '0;
            fault_q  <= 1'b1;
        end
    end

    AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> ($stable(paddr_q) && $stable(rights_q) && $stable(fault_q))); // R7
    AST_FAULT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && fault_q) |-> (paddr_q == '0 && rights_q == '0)); // R5
endmodule

// File: rtl/page_walk2.sv
// Module: page_walk2
// Top of the two-level page table walker: wires the request holder, address
// arithmetic, walk control and response register together.
// Assumes: the memory answers every read exactly once; entries are word sized.
module page_walk2 #(
    parameter int ADDR_W     = pw_pkg::PW_ADDR_W,
    parameter int OFF_W      = pw_pkg::PW_OFF_W,
    parameter int IDX_W      = pw_pkg::PW_IDX_W,
    parameter int WORD_BYTES = pw_pkg::PW_WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_laddr,
    input  logic [ADDR_W-1:0] root_base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [OFF_W-1:0]  rsp_rights,
    output logic              rsp_fault
);
    localparam int LOW_W = ADDR_W - IDX_W;

    logic              accept, cap_ok, cap_fault, present;
    logic [LOW_W-1:0]  low_q;
    logic [ADDR_W-1:0] l1_addr, l2_addr, paddr_c;
    logic [OFF_W-1:0]  rights_c;

    pw_req_hold #(.LOW_W(LOW_W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (accept),
        .low_in (req_laddr[LOW_W-1:0]),
        .low_q  (low_q)
    );

    pw_addr_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .WORD_BYTES(WORD_BYTES)) u_calc (
        .dir_idx  (req_laddr[ADDR_W-1:LOW_W]),
        .root     (root_base),
        .held_low (low_q),
        .entry    (mem_rdata),
        .l1_addr  (l1_addr),
        .l2_addr  (l2_addr),
        .present  (present),
        .paddr    (paddr_c),
        .rights   (rights_c)
    );

    pw_walk_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .l1_addr    (l1_addr),
        .l2_addr    (l2_addr),
        .present    (present),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .accept     (accept),
        .cap_ok     (cap_ok),
        .cap_fault  (cap_fault)
    );

    pw_rsp_reg #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_ok    (cap_ok),
        .cap_fault (cap_fault),
        .paddr_in  (paddr_c),
        .rights_in (rights_c),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .paddr_q   (rsp_paddr),
        .rights_q  (rsp_rights),
        .fault_q   (rsp_fault)
    );
endmodule

// File: tb/sim_page_walk2.sv
// Bench for page_walk2: the bench plays the memory and walks a vector table,
// then runs directed reset and ignore tests.
module sim_page_walk2;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_laddr = '0;
    logic [31:0] root_base = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [11:0] rsp_rights;
    logic        rsp_fault;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    page_walk2 u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_laddr(req_laddr), .root_base(root_base), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_rights(rsp_rights), .rsp_fault(rsp_fault)
    );

    // Fields: laddr, root, root entry, leaf entry, expected paddr,
    // {fault, 3'b0, rights}, memory latency, response hold cycles.
    localparam logic [191:0] VECS [6] = '{
        {32'h0040_3ABC, 32'h0001_0000, 32'h0002_0001, 32'h1234_5A5F, 32'h1234_5ABC, 16'h0A5F, 8'd0, 8'd0},
        {32'hFFFF_FFFF, 32'h0008_0000, 32'hFFFF_F001, 32'hABCD_EFFF, 32'hABCD_EFFF, 16'h0FFF, 8'd3, 8'd2},
        {32'h0000_0000, 32'h0000_0000, 32'h0000_1001, 32'h0000_0000, 32'h0000_0000, 16'h0000, 8'd1, 8'd0},
        {32'h8020_1004, 32'h0003_0000, 32'h7777_7000, 32'h0000_0000, 32'h0000_0000, 16'h8000, 8'd2, 8'd1},
        {32'h0C00_2010, 32'h0004_0000, 32'h0005_5FFF, 32'h0000_F123, 32'h0000_F010, 16'h0123, 8'd5, 8'd3},
        {32'h1234_5678, 32'h0000_0000, 32'hFFFF_FFFE, 32'h0000_0000, 32'h0000_0000, 16'h8000, 8'd0, 8'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Memory model: wait lat cycles with no new request, then return data.
    task automatic mem_reply(input int lat, input logic [31:0] data);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk("R9 no request while waiting", {31'd0, mem_req}, 32'd0);
        end
        mem_rvalid = 1'b1;
        mem_rdata  = data;
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
    endtask

    task automatic run_walk(input logic [191:0] v);
        logic [31:0] la, root, e1, e2, epa, el1, el2;
        logic [15:0] ert;
        int lat, hold;
        la = v[191:160]; root = v[159:128]; e1 = v[127:96]; e2 = v[95:64];
        epa = v[63:32]; ert = v[31:16]; lat = int'(v[15:8]); hold = int'(v[7:0]);
        el1 = root + {20'd0, la[31:22], 2'b00};
        el2 = {e1[31:12], 12'h000} + {20'd0, la[21:12], 2'b00};

        @(negedge clk);
        chk("R2 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_laddr = la; root_base = root;
        @(negedge clk);
        // keep req_valid high on longer vectors and scramble inputs (R2)
        req_valid = (hold > 1); req_laddr = ~la; root_base = ~root;
        chk("R2 busy after accept", {31'd0, req_ready}, 32'd0);
        chk("R3 root read issued", {31'd0, mem_req}, 32'd1);
        chk("R3 root entry address", mem_addr, el1);
        mem_reply(lat, e1);
        if (e1[0]) begin
            chk("R4 leaf read issued", {31'd0, mem_req}, 32'd1);
            chk("R4 leaf entry address", mem_addr, el2);
            chk("R4 no response yet", {31'd0, rsp_valid}, 32'd0);
            mem_reply(lat, e2);
            chk("R6 response valid", {31'd0, rsp_valid}, 32'd1);
        end else begin
            chk("R5 no leaf read", {31'd0, mem_req}, 32'd0);
            chk("R5 response valid", {31'd0, rsp_valid}, 32'd1);
        end
        chk("R6 paddr", rsp_paddr, epa);
        chk("R6 rights", {20'd0, rsp_rights}, {20'd0, ert[11:0]});
        chk("R5 fault flag", {31'd0, rsp_fault}, {31'd0, ert[15]});
        for (int i = 0; i < hold; i++) begin
            // stray read data while holding a response (R8)
            mem_rvalid = (hold > 1); mem_rdata = ~e2;
            @(negedge clk);
            mem_rvalid = 1'b0; mem_rdata = '0;
            chk("R7 response held", {31'd0, rsp_valid}, 32'd1);
            chk("R8 paddr unchanged", rsp_paddr, epa);
            chk("R7 rights held", {20'd0, rsp_rights}, {20'd0, ert[11:0]});
            chk("R2 still busy", {31'd0, req_ready}, 32'd0);
        end
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R7 response released", {31'd0, rsp_valid}, 32'd0);
        chk("R7 ready again", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R1 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 reset mem_req", {31'd0, mem_req}, 32'd0);

        foreach (VECS[i]) run_walk(VECS[i]);

        // R8: read data while idle starts nothing
        mem_rvalid = 1'b1; mem_rdata = 32'h0009_9001;
        repeat (2) @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = '0;
        @(negedge clk);
        chk("R8 idle mem_req", {31'd0, mem_req}, 32'd0);
        chk("R8 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R8 idle ready", {31'd0, req_ready}, 32'd1);

        // R1: reset in the middle of a walk returns to idle
        req_valid = 1'b1; req_laddr = 32'h0040_3ABC; root_base = 32'h0001_0000;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 walk started", {31'd0, mem_req}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mid-walk reset ready", {31'd0, req_ready}, 32'd1);
        chk("R1 mid-walk reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("R1 mid-walk reset rsp_valid", {31'd0, rsp_valid}, 32'd0);

        // walker works normally after that reset
        run_walk(VECS[1]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule